// File: doc/BRIEF.md
# Square-Wave Output and Oscillator Status Control

This block owns the control byte of a real-time clock that sets what the open-drain square-wave pin does and records whether the timekeeping oscillator has ever stopped. The pin either repeats one of four divided rates of the 32.768 kHz oscillator or holds a static level that software picks. All rates below the oscillator rate come from taps of one shared binary divider. The divider can be cleared by the seconds-register write, so the slowest rate stays in phase with the seconds count.

The oscillator stop flag is sticky. It is preset at power-up and set again whenever the oscillator-running input falls. Software can clear it by writing 0 to it, but a write of 1 never sets it. The control byte is written and read through a plain register port that is one byte wide. The pin is represented by an output-enable signal: when the enable is high the pin is pulled low, and when it is low the pin is released.

Top module: `sqwave_ctrl`

## Requirements
- R1: The read port shows the control byte with OUT at bit 7, the stop flag at bit 5, the wave-enable at bit 4 and the rate code at bits 1:0. After reset the read value is 8'hA0: OUT=1, stop flag=1, wave-enable=0, rate 0.
- R2: While the wave-enable is 1, the output level follows the rate code. Code 0 selects divider bit DIV_W-1, which is 1 Hz at the default width. Code 1 selects divider bit 2 (4.096 kHz). Code 2 selects divider bit 1 (8.192 kHz). Code 3 selects the synchronised oscillator level itself. The divider adds one on every rising edge of `xtal_i` while `osc_run_i` is high.
- R3: While the wave-enable is 0, the output level equals the OUT bit.
- R4: `pin_oe_o` is registered. In the cycle after the output level is 0 it is 1 (the pin is pulled low), and in the cycle after the level is 1 it is 0 (the pin is released). It is 0 in reset.
- R5: A fall of `osc_run_i` sets the stop flag, and the flag reads 1 in the following cycle.
- R6: A write with bit 5 at 0 clears the stop flag. A write with bit 5 at 1 leaves the flag as it was. A stop event in the same cycle as a clearing write leaves the flag at 1.
- R7: A pulse on `pre_clr_i` clears the divider. With rate 0 selected, the pin then pulls low and is released after 2^(DIV_W-1) oscillator rising edges, which is half a second at the default width.
- R8: While `osc_run_i` is low the divider holds, so a divided output stays frozen even if `xtal_i` keeps toggling.
- R9: Written values of bits 6, 3 and 2 are ignored, and these bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| xtal_i | input | 1 | 32.768 kHz oscillator level |
| osc_run_i | input | 1 | High while the oscillator runs (clock-halt low) |
| pre_clr_i | input | 1 | Divider clear pulse from a seconds write |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte write data |
| rd_data_o | output | 8 | Control byte read data |
| pin_oe_o | output | 1 | Square-wave pin pull-down enable |

## Verification
The bench builds the block with DIV_W=6. With this width the slowest tap is divider bit 5, one period of that rate is 64 oscillator edges, and the half-period realignment after a divider clear takes 32 edges. Several full periods of every rate, a stop while the slow output is frozen, and a stop in the same cycle as a clearing write therefore all happen within a few thousand clocks. The bench drives the oscillator at a period of eight system clocks, so the 4.096 kHz and 8.192 kHz taps show several edges in every phase.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef enum logic [1:0] {
    RATE_SLOW = 2'd0,
    RATE_4K   = 2'd1,
    RATE_8K   = 2'd2,
    RATE_OSC  = 2'd3
  } rate_e;

  typedef struct packed {
    logic  out;
    logic  osf;
    logic  sqwe;
    rate_e rate;
  } ctrl_t;

  localparam int unsigned BIT_OUT  = 7;
  localparam int unsigned BIT_OSF  = 5;
  localparam int unsigned BIT_SQWE = 4;
  localparam int unsigned NUM_RATE = 4;

  // divider bit feeding each divided rate code
  function automatic int unsigned tap_of(input int unsigned code, input int unsigned div_w);
    case (code)
      0:       return div_w - 1;
      1:       return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int unsigned DIV_W = 15
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         xtal_i,
  input  logic                         run_i,
  input  logic                         clr_i,
  output logic [sqw_pkg::NUM_RATE-1:0] waves_o
);
  import sqw_pkg::*;

  logic             xs_q, xs_d_q;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             rise;
  logic             cnt_en;

  assign rise   = xs_q & ~xs_d_q;
  assign cnt_en = clr_i | (rise & run_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (rise && run_i)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs_q   <= 1'b0;
      xs_d_q <= 1'b0;
    end else begin
      xs_q   <= xtal_i;
      xs_d_q <= xs_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < NUM_RATE - 1; k++) begin : g_tap
    localparam int unsigned TAP = tap_of(k, DIV_W);
    assign waves_o[k] = cnt_q[TAP];
  end
  assign waves_o[NUM_RATE-1] = xs_q;

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)); // R7

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !run_i) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/sqw_status.sv
module sqw_status (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [7:0]    wr_data_i,
  input  logic          run_i,
  output sqw_pkg::ctrl_t ctrl_o
);
  import sqw_pkg::*;

  ctrl_t ctrl_q, ctrl_d;
  logic  run_q;
  logic  stop_evt;

  assign stop_evt = run_q & ~run_i;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) begin
      ctrl_d.out  = wr_data_i[BIT_OUT];
      ctrl_d.sqwe = wr_data_i[BIT_SQWE];
      ctrl_d.rate = rate_e'(wr_data_i[1:0]);
      if (!wr_data_i[BIT_OSF])
        ctrl_d.osf = 1'b0;
    end
    if (stop_evt)
      ctrl_d.osf = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{out: 1'b1, osf: 1'b1, sqwe: 1'b0, rate: RATE_SLOW};
      run_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      run_q  <= run_i;
    end
  end

  assign ctrl_o = ctrl_q;

  AST_OSF_SET_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> ctrl_q.osf); // R5

  AST_OSF_NOT_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.osf && !stop_evt) |=> !ctrl_q.osf); // R6

  AST_OSF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_data_i[BIT_OSF] && !stop_evt) |=> !ctrl_q.osf); // R6

endmodule

// File: rtl/sqw_outmux.sv
module sqw_outmux (
  input  logic                         clk,
  input  logic                         rst_n,
  input  sqw_pkg::ctrl_t               ctrl_i,
  input  logic [sqw_pkg::NUM_RATE-1:0] waves_i,
  output logic                         pin_oe_o
);
  import sqw_pkg::*;

  logic level;
  logic oe_q, oe_d;

  always_comb begin
    if (ctrl_i.sqwe)
      level = waves_i[ctrl_i.rate];
    else
      level = ctrl_i.out;
    oe_d = ~level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      oe_q <= 1'b0;
    else
      oe_q <= oe_d;
  end

  assign pin_oe_o = oe_q;

  AST_STATIC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i.sqwe |=> (pin_oe_o == !$past(ctrl_i.out))); // R3

  AST_FAST_FOLLOWS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.sqwe && ctrl_i.rate == RATE_OSC) |=> (pin_oe_o == !$past(waves_i[NUM_RATE-1]))); // R2

endmodule

// File: rtl/sqwave_ctrl.sv
module sqwave_ctrl #(
  parameter int unsigned DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_i,
  input  logic       osc_run_i,
  input  logic       pre_clr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       pin_oe_o
);
  import sqw_pkg::*;

  ctrl_t               ctrl;
  logic [NUM_RATE-1:0] waves;

  sqw_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .xtal_i  (xtal_i),
    .run_i   (osc_run_i),
    .clr_i   (pre_clr_i),
    .waves_o (waves)
  );

  sqw_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .run_i     (osc_run_i),
    .ctrl_o    (ctrl)
  );

  sqw_outmux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_i   (ctrl),
    .waves_i  (waves),
    .pin_oe_o (pin_oe_o)
  );

  always_comb begin
    rd_data_o           = '0;
    rd_data_o[BIT_OUT]  = ctrl.out;
    rd_data_o[BIT_OSF]  = ctrl.osf;
    rd_data_o[BIT_SQWE] = ctrl.sqwe;
    rd_data_o[1:0]      = ctrl.rate;
  end

  always_ff @(posedge clk) begin
    if (rst_n)
      AST_SPARE_BITS_ZERO: assert ({rd_data_o[6], rd_data_o[3:2]} == 3'b000); // R9
  end

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (rd_data_o[BIT_SQWE] == $past(wr_data_i[BIT_SQWE]))); // R1

endmodule

// File: tb/sqwave_ctrl_test.sv
module sqwave_ctrl_test;

  localparam int unsigned DIVW = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xtal = 1'b0;
  logic       osc_run = 1'b1;
  logic       pre_clr = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       pin_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sqwave_ctrl #(.DIV_W(DIVW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .xtal_i    (xtal),
    .osc_run_i (osc_run),
    .pre_clr_i (pre_clr),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .pin_oe_o  (pin_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // behavioural reference, advanced on each rising clock
  int   m_cnt;
  bit   m_xs, m_xsd, m_run, m_out, m_sqwe, m_osf, m_oe;
  int   m_rate;
  bit   model_on = 1'b0;

  function automatic bit m_level();
    if (!m_sqwe) return m_out;
    case (m_rate)
      0: return bit'((m_cnt >> (DIVW - 1)) & 1);
      1: return bit'((m_cnt >> 2) & 1);
      2: return bit'((m_cnt >> 1) & 1);
      default: return m_xs;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_xs = 0; m_xsd = 0; m_run = 0;
      m_out = 1; m_sqwe = 0; m_osf = 1; m_oe = 0; m_rate = 0;
    end else begin
      bit lvl;
      bit rise;
      lvl  = m_level();
      rise = m_xs && !m_xsd;
      m_oe = !lvl;
      if (pre_clr) m_cnt = 0;
      else if (rise && osc_run) m_cnt = (m_cnt + 1) % (1 << DIVW);
      if (wr_en) begin
        m_out  = wr_data[7];
        m_sqwe = wr_data[4];
        m_rate = int'(wr_data[1:0]);
        if (!wr_data[5]) m_osf = 0;
      end
      if (m_run && !osc_run) m_osf = 1;
      m_xsd = m_xs;
      m_xs  = xtal;
      m_run = osc_run;
    end
  end

  function automatic logic [7:0] m_rd();
    return {m_out, 1'b0, m_osf, m_sqwe, 2'b00, 2'(m_rate)};
  endfunction

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk("R1 R9 readback model", rd_data, m_rd());
      chk("R2 R3 R4 pin model", {7'd0, pin_oe}, {7'd0, m_oe});
    end
  end

  // oscillator: period of eight system clocks
  initial begin
    forever begin
      repeat (4) @(negedge clk);
      xtal = ~xtal;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    chk("R1 reset value", rd_data, 8'hA0);
    chk("R4 released in reset state", {7'd0, pin_oe}, 8'h00);

    // static low, stop flag cleared
    wr_ctrl(8'h00);
    @(negedge clk);
    chk("R3 static level 0 pulls pin", {7'd0, pin_oe}, 8'h01);
    chk("R6 write 0 clears flag", rd_data, 8'h00);

    // all ones: flag not set by a write of 1, spare bits dropped
    wr_ctrl(8'hFF);
    chk("R9 spare bits read 0", rd_data, 8'h93);
    chk("R6 write 1 leaves flag clear", {7'd0, rd_data[5]}, 8'h00);
    repeat (200) @(negedge clk);

    wr_ctrl(8'h11);
    repeat (300) @(negedge clk);
    wr_ctrl(8'h12);
    repeat (300) @(negedge clk);

    // slow rate realigned by a divider clear
    wr_ctrl(8'h10);
    @(negedge clk);
    pre_clr = 1'b1;
    @(negedge clk);
    pre_clr = 1'b0;
    @(negedge clk);
    chk("R7 slow output low after clear", {7'd0, pin_oe}, 8'h01);
    begin
      int waited = 2;
      while (pin_oe && waited < 400) begin
        @(negedge clk);
        waited++;
      end
      n_cmp++;
      if (waited < 240 || waited > 272) begin
        n_bad++;
        $display("FAIL R7 half period cycles actual=%0d expected=240..272", waited);
      end
    end
    repeat (700) @(negedge clk);

    // oscillator stop: flag set, slow output frozen
    osc_run = 1'b0;
    @(negedge clk);
    chk("R5 flag set on stop", {7'd0, rd_data[5]}, 8'h01);
    begin
      logic held = pin_oe;
      for (int i = 0; i < 150; i++) begin
        @(negedge clk);
        n_cmp++;
        if (pin_oe !== held) begin
          n_bad++;
          $display("FAIL R8 frozen output actual=%b expected=%b", pin_oe, held);
        end
      end
    end

    // restart, clear the flag, then stop in the same cycle as a clearing write
    osc_run = 1'b1;
    wr_ctrl(8'h10);
    chk("R6 flag cleared while running", {7'd0, rd_data[5]}, 8'h00);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 8'h10;
    osc_run = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R6 stop wins over clearing write", {7'd0, rd_data[5]}, 8'h01);
    osc_run = 1'b1;
    repeat (20) @(negedge clk);

    // oscillator pass-through and static high
    wr_ctrl(8'h13);
    repeat (100) @(negedge clk);
    wr_ctrl(8'h80);
    @(negedge clk);
    chk("R3 static level 1 releases pin", {7'd0, pin_oe}, 8'h00);
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule